// File: doc/BRIEF.md
# Macropixel Hit Readout Periphery

This block is the digital periphery that collects hits from a pixel matrix split into square macropixels. Every macropixel drives one private fast-OR line toward the periphery and receives one private latch-enable line back. As soon as a macropixel reports activity, the periphery marks it as fired, saves the value of a global timestamp counter for it, and drops its latch enable so that the pixel contents stay frozen until they are read.

A scanner then takes the fired macropixels one at a time, lowest index first. It steps through every column of the chosen macropixel, reading that column's hit bits through a select address, and emits one word per hit pixel on a valid/ready output bus. After the last column it pulses a clear strobe that resets the macropixel's pixels and opens its latch enable again. Hits that reach a frozen macropixel are lost by design.

Top module: `mphr_readout`

## Requirements
- R1: After reset every latch-enable line is high, and out_valid and clr_en are low.
- R2: A fast-OR that is high on an open macropixel drives that macropixel's latch enable low from the next cycle on, and the timestamp counter value of that cycle is stored with it.
- R3: While a macropixel's latch enable is low, hits that reach it produce no output word.
- R4: Each word is laid out as bits [19:12] stored timestamp, [11:4] macropixel index, [3:2] row inside the macropixel, [1:0] column inside the macropixel; the macropixel index of the pixel at column c, row r is (r/4)*8 + c/4.
- R5: Within one macropixel, words leave column 0 to column 3, and inside a column in ascending row order.
- R6: All four columns of a selected macropixel are scanned; a column without hits takes exactly one cycle, so with out_ready held high a hit in column 0 and the next one in column 3 are accepted four cycles apart.
- R7: When several macropixels are fired, the lowest macropixel index is read out first.
- R8: One cycle after the last column is scanned clr_en pulses for one cycle with sel_mp naming the macropixel, and its latch enable is high in the cycle after that.
- R9: The timestamp counter increases by one on each clock edge where ts_strobe is high and wraps modulo 256.
- R10: While out_valid is high and out_ready low, out_valid stays high and out_data does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_strobe | input | 1 | Timestamp advance strobe |
| mp_fastor | input | 256 | Fast-OR line of each macropixel |
| mp_latch_en | output | 256 | Latch enable per macropixel, low while frozen |
| sel_en | output | 1 | A macropixel column is being read |
| sel_mp | output | 8 | Selected macropixel index |
| sel_col | output | 2 | Selected column inside the macropixel |
| col_hits | input | 4 | Hit bits of the selected column, bit i = row i |
| clr_en | output | 1 | Clear strobe for the macropixel named by sel_mp |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Output word accepted |
| out_data | output | 20 | Formatted hit word |

## Verification
The assertions assume that col_hits reflects the frozen contents of the selected column and so stays constant while a column is held under backpressure, and that a macropixel's fast-OR falls once its clear strobe has been applied. The bench meets this with a behavioural hit array that only accepts new hits while the matching latch enable is high, clears a macropixel on the clear strobe, and derives fast-OR and the column bits from that array alone. Stimulus is applied on falling edges, and the timestamp strobe is kept still around each injection so the expected stamp is unambiguous.

// File: rtl/mphr_pkg.sv
`timescale 1ns/1ps
package mphr_pkg;
  localparam int unsigned DEF_COLS = 32;
  localparam int unsigned DEF_ROWS = 128;
  localparam int unsigned DEF_SIDE = 4;
  localparam int unsigned DEF_TS_W = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_REL} scan_state_e;

  // macropixel number of a pixel, row-major over macropixels
  function automatic int unsigned mp_of_pixel(int unsigned col, int unsigned row,
                                              int unsigned side, int unsigned cols);
    return (row / side) * (cols / side) + col / side;
  endfunction
endpackage

// File: rtl/mphr_ts_counter.sv
`timescale 1ns/1ps
module mphr_ts_counter #(
  parameter int unsigned TS_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strobe,
  output logic [TS_W-1:0] ts_now
);
  always_ff @(posedge clk) begin
    if (!rst_n)      ts_now <= '0;
    else if (strobe) ts_now <= ts_now + 1'b1;
  end
endmodule

// File: rtl/mphr_hit_bank.sv
`timescale 1ns/1ps
module mphr_hit_bank #(
  parameter int unsigned NMP   = 256,
  parameter int unsigned MPI_W = 8,
  parameter int unsigned TS_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NMP-1:0]   fastor,
  input  logic [TS_W-1:0]  ts_now,
  input  logic             rel_en,
  input  logic [MPI_W-1:0] rel_idx,
  input  logic [MPI_W-1:0] rd_idx,
  output logic [NMP-1:0]   fired,
  output logic [TS_W-1:0]  ts_rd
);
  logic [TS_W-1:0] ts_mem [NMP];
  logic [NMP-1:0]  new_fire;

  assign new_fire = fastor & ~fired;

  for (genvar m = 0; m < NMP; m++) begin : g_mp
    always_ff @(posedge clk) begin
      if (!rst_n)                                        fired[m] <= 1'b0;
      else if (rel_en && rel_idx == MPI_W'(m))           fired[m] <= 1'b0;
      else if (new_fire[m])                              fired[m] <= 1'b1;
    end
    always_ff @(posedge clk) begin
      if (new_fire[m]) ts_mem[m] <= ts_now;
    end
  end

  assign ts_rd = ts_mem[rd_idx];
endmodule

// File: rtl/mphr_arbiter.sv
`timescale 1ns/1ps
module mphr_arbiter #(
  parameter int unsigned NMP   = 256,
  parameter int unsigned MPI_W = 8
) (
  input  logic [NMP-1:0]   req,
  output logic             any,
  output logic [MPI_W-1:0] pick
);
  always_comb begin
    pick = '0;
    for (int i = NMP - 1; i >= 0; i--) begin
      if (req[i]) pick = MPI_W'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/mphr_scanner.sv
`timescale 1ns/1ps
module mphr_scanner
  import mphr_pkg::*;
#(
  parameter int unsigned SIDE   = 4,
  parameter int unsigned MPI_W  = 8,
  parameter int unsigned TS_W   = 8,
  parameter int unsigned SUB_W  = 2,
  parameter int unsigned WORD_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_fired,
  input  logic [MPI_W-1:0]  pick_idx,
  input  logic [SIDE-1:0]   col_hits,
  input  logic [TS_W-1:0]   ts_rd,
  input  logic              out_ready,
  output logic              sel_en,
  output logic [MPI_W-1:0]  sel_mp,
  output logic [SUB_W-1:0]  sel_col,
  output logic              clr_en,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data
);
  scan_state_e      state;
  logic [MPI_W-1:0] cur_mp;
  logic [SUB_W-1:0] cur_col;
  logic [SIDE-1:0]  done_rows;
  logic [SIDE-1:0]  pend;
  logic [SUB_W-1:0] row_pick;
  logic             col_empty;
  logic             last_col;
  logic             word_taken;

  function automatic logic [SUB_W-1:0] lowest_row(logic [SIDE-1:0] v);
    lowest_row = '0;
    for (int i = SIDE - 1; i >= 0; i--) begin
      if (v[i]) lowest_row = SUB_W'(i);
    end
  endfunction

  assign sel_en     = (state == ST_SCAN);
  assign pend       = sel_en ? (col_hits & ~done_rows) : '0;
  assign row_pick   = lowest_row(pend);
  assign col_empty  = (pend == '0);
  assign last_col   = (cur_col == SUB_W'(SIDE - 1));
  assign out_valid  = sel_en && !col_empty;
  assign word_taken = out_valid && out_ready;
  assign clr_en     = (state == ST_REL);
  assign sel_mp     = cur_mp;
  assign sel_col    = cur_col;
  assign out_data   = {ts_rd, cur_mp, row_pick, cur_col};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_mp    <= '0;
      cur_col   <= '0;
      done_rows <= '0;
    end else begin
      case (state)
        ST_IDLE: if (any_fired) begin
          cur_mp    <= pick_idx;
          cur_col   <= '0;
          done_rows <= '0;
          state     <= ST_SCAN;
        end
        ST_SCAN: begin
          if (word_taken) begin
            done_rows <= done_rows | (SIDE'(1) << row_pick);
          end else if (col_empty) begin
            done_rows <= '0;
            if (last_col) state <= ST_REL;
            else          cur_col <= cur_col + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mphr_readout.sv
`timescale 1ns/1ps
module mphr_readout
  import mphr_pkg::*;
#(
  parameter int unsigned COLS = DEF_COLS,
  parameter int unsigned ROWS = DEF_ROWS,
  parameter int unsigned SIDE = DEF_SIDE,
  parameter int unsigned TS_W = DEF_TS_W,
  localparam int unsigned NMP    = (COLS / SIDE) * (ROWS / SIDE),
  localparam int unsigned MPI_W  = $clog2(NMP),
  localparam int unsigned SUB_W  = $clog2(SIDE),
  localparam int unsigned WORD_W = TS_W + MPI_W + 2 * SUB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ts_strobe,
  input  logic [NMP-1:0]    mp_fastor,
  output logic [NMP-1:0]    mp_latch_en,
  output logic              sel_en,
  output logic [MPI_W-1:0]  sel_mp,
  output logic [SUB_W-1:0]  sel_col,
  input  logic [SIDE-1:0]   col_hits,
  output logic              clr_en,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);
  logic [TS_W-1:0]  ts_now;
  logic [TS_W-1:0]  ts_rd;
  logic [NMP-1:0]   fired;
  logic             any_fired;
  logic [MPI_W-1:0] pick_idx;

  mphr_ts_counter #(.TS_W(TS_W)) u_ts (
    .clk(clk), .rst_n(rst_n), .strobe(ts_strobe), .ts_now(ts_now)
  );

  mphr_hit_bank #(.NMP(NMP), .MPI_W(MPI_W), .TS_W(TS_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .fastor(mp_fastor), .ts_now(ts_now),
    .rel_en(clr_en), .rel_idx(sel_mp), .rd_idx(sel_mp),
    .fired(fired), .ts_rd(ts_rd)
  );

  mphr_arbiter #(.NMP(NMP), .MPI_W(MPI_W)) u_arb (
    .req(fired), .any(any_fired), .pick(pick_idx)
  );

  mphr_scanner #(.SIDE(SIDE), .MPI_W(MPI_W), .TS_W(TS_W),
                 .SUB_W(SUB_W), .WORD_W(WORD_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .any_fired(any_fired), .pick_idx(pick_idx),
    .col_hits(col_hits), .ts_rd(ts_rd), .out_ready(out_ready),
    .sel_en(sel_en), .sel_mp(sel_mp), .sel_col(sel_col), .clr_en(clr_en),
    .out_valid(out_valid), .out_data(out_data)
  );

  assign mp_latch_en = ~fired;
endmodule

// File: rtl/mphr_readout_sva.sv
`timescale 1ns/1ps
module mphr_readout_sva #(
  parameter int unsigned NMP    = 256,
  parameter int unsigned MPI_W  = 8,
  parameter int unsigned SUB_W  = 2,
  parameter int unsigned WORD_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NMP-1:0]    mp_fastor,
  input logic [NMP-1:0]    mp_latch_en,
  input logic              sel_en,
  input logic [MPI_W-1:0]  sel_mp,
  input logic              clr_en,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data
);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_read_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_en |-> !mp_latch_en[sel_mp]);

  p_valid_in_scan_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> sel_en);

  p_release_opens_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> mp_latch_en[$past(sel_mp)]);

  p_clr_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> !out_valid && !sel_en);

  for (genvar k = 0; k < NMP; k++) begin : g_fz
    p_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mp_fastor[k] && mp_latch_en[k] |=> !mp_latch_en[k]);
  end
endmodule

bind mphr_readout mphr_readout_sva #(
  .NMP(NMP), .MPI_W(MPI_W), .SUB_W(SUB_W), .WORD_W(WORD_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .mp_fastor(mp_fastor), .mp_latch_en(mp_latch_en),
  .sel_en(sel_en), .sel_mp(sel_mp), .clr_en(clr_en), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data)
);

// File: tb/mphr_readout_tb_top.sv
`timescale 1ns/1ps
module mphr_readout_tb_top;
  localparam int NMP = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ts_strobe = 1'b0;
  logic [NMP-1:0] mp_fastor;
  logic [NMP-1:0] mp_latch_en;
  logic        sel_en;
  logic [7:0]  sel_mp;
  logic [1:0]  sel_col;
  logic [3:0]  col_hits;
  logic        clr_en;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [19:0] out_data;

  logic [15:0] hits    [NMP];
  logic [15:0] inj_req [NMP];

  int nchk = 0, nerr = 0, cyc = 0, nlog = 0, ts_model = 0;
  logic [19:0] wlog [64];
  int          wcyc [64];

  always #10 clk = ~clk;

  mphr_readout dut_i (
    .clk(clk), .rst_n(rst_n), .ts_strobe(ts_strobe), .mp_fastor(mp_fastor),
    .mp_latch_en(mp_latch_en), .sel_en(sel_en), .sel_mp(sel_mp), .sel_col(sel_col),
    .col_hits(col_hits), .clr_en(clr_en), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  // behavioural pixel matrix: bit index = row_in*4 + col_in
  always @(posedge clk) begin
    for (int m = 0; m < NMP; m++) begin
      if (!rst_n)                            hits[m] <= '0;
      else if (clr_en && sel_mp == 8'(m))    hits[m] <= '0;
      else if (mp_latch_en[m])               hits[m] <= hits[m] | inj_req[m];
    end
  end

  always_comb begin
    for (int m = 0; m < NMP; m++) mp_fastor[m] = |hits[m];
    for (int r = 0; r < 4; r++)   col_hits[r] = hits[sel_mp][r*4 + int'(sel_col)];
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && out_valid && out_ready && nlog < 64) begin
      wlog[nlog] <= out_data;
      wcyc[nlog] <= cyc;
      nlog <= nlog + 1;
    end
  end

  function automatic logic [19:0] expw(int ts, int mp, int r, int c);
    return 20'((ts % 256) * 4096 + mp * 16 + r * 4 + c);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic inject(int mp, int b);
    @(negedge clk); inj_req[mp][b] = 1'b1;
    @(negedge clk); inj_req[mp][b] = 1'b0;
  endtask

  task automatic strobe(int n);
    @(negedge clk); ts_strobe = 1'b1;
    repeat (n) @(negedge clk);
    ts_strobe = 1'b0;
    ts_model += n;
  endtask

  task automatic drain();
    repeat (30) @(negedge clk);
  endtask

  task automatic t_reset();
    check(mp_latch_en == '1, "R1 latch", 32'(mp_latch_en[31:0]), 32'hffffffff);
    check(!out_valid && !clr_en, "R1 idle", {30'd0, out_valid, clr_en}, 32'd0);
  endtask

  task automatic t_single();
    int base;
    strobe(5);
    base = nlog;
    // pixel col 13, row 70 -> mp 139, row_in 2, col_in 1
    inject(139, 9);
    check(mp_latch_en[139] == 1'b1, "R2 open", 32'(mp_latch_en[139]), 32'd1);
    @(negedge clk);
    check(mp_latch_en[139] == 1'b0, "R2 frozen", 32'(mp_latch_en[139]), 32'd0);
    drain();
    check(nlog - base == 1, "R4 count", 32'(nlog - base), 32'd1);
    check(wlog[base] == expw(ts_model, 139, 2, 1), "R4 word",
          32'(wlog[base]), 32'(expw(ts_model, 139, 2, 1)));
  endtask

  task automatic t_drop();
    int base;
    base = nlog;
    out_ready = 1'b0;
    inject(40, 0);
    repeat (2) @(negedge clk);
    check(mp_latch_en[40] == 1'b0, "R3 frozen", 32'(mp_latch_en[40]), 32'd0);
    inject(40, 15);
    repeat (3) @(negedge clk);
    out_ready = 1'b1;
    drain();
    check(nlog - base == 1, "R3 dropped", 32'(nlog - base), 32'd1);
    check(wlog[base] == expw(ts_model, 40, 0, 0), "R3 first word",
          32'(wlog[base]), 32'(expw(ts_model, 40, 0, 0)));
    inject(40, 15);
    drain();
    check(nlog - base == 2, "R3 after release", 32'(nlog - base), 32'd2);
    check(wlog[base+1] == expw(ts_model, 40, 3, 3), "R3 reopened word",
          32'(wlog[base+1]), 32'(expw(ts_model, 40, 3, 3)));
  endtask

  task automatic t_order();
    int base;
    base = nlog;
    @(negedge clk);
    inj_req[7] = 16'h1214;  // bits 12,4,2,9: (r3,c0)(r1,c0)(r0,c2)(r2,c1)
    @(negedge clk);
    inj_req[7] = '0;
    drain();
    check(nlog - base == 4, "R5 count", 32'(nlog - base), 32'd4);
    check(wlog[base]   == expw(ts_model, 7, 1, 0), "R5 w0", 32'(wlog[base]),   32'(expw(ts_model, 7, 1, 0)));
    check(wlog[base+1] == expw(ts_model, 7, 3, 0), "R5 w1", 32'(wlog[base+1]), 32'(expw(ts_model, 7, 3, 0)));
    check(wlog[base+2] == expw(ts_model, 7, 2, 1), "R5 w2", 32'(wlog[base+2]), 32'(expw(ts_model, 7, 2, 1)));
    check(wlog[base+3] == expw(ts_model, 7, 0, 2), "R5 w3", 32'(wlog[base+3]), 32'(expw(ts_model, 7, 0, 2)));
  endtask

  task automatic t_empty_cols();
    int base;
    base = nlog;
    @(negedge clk);
    inj_req[9] = 16'h0009;  // (r0,c0) and (r0,c3)
    @(negedge clk);
    inj_req[9] = '0;
    drain();
    check(nlog - base == 2, "R6 count", 32'(nlog - base), 32'd2);
    check(wcyc[base+1] - wcyc[base] == 4, "R6 gap", 32'(wcyc[base+1] - wcyc[base]), 32'd4);
  endtask

  task automatic t_prio();
    int base;
    base = nlog;
    @(negedge clk);
    inj_req[200] = 16'h0001;
    inj_req[3]   = 16'h0020;
    @(negedge clk);
    inj_req[200] = '0;
    inj_req[3]   = '0;
    drain();
    check(nlog - base == 2, "R7 count", 32'(nlog - base), 32'd2);
    check(wlog[base]   == expw(ts_model, 3, 1, 1), "R7 first",
          32'(wlog[base]), 32'(expw(ts_model, 3, 1, 1)));
    check(wlog[base+1] == expw(ts_model, 200, 0, 0), "R7 second",
          32'(wlog[base+1]), 32'(expw(ts_model, 200, 0, 0)));
  endtask

  task automatic t_release();
    int n = 0;
    bit seen = 0;
    inject(50, 5);
    while (!seen && n < 40) begin
      @(negedge clk);
      n++;
      if (clr_en) begin
        seen = 1;
        check(sel_mp == 8'd50, "R8 clr index", 32'(sel_mp), 32'd50);
        check(mp_latch_en[50] == 1'b0, "R8 still frozen", 32'(mp_latch_en[50]), 32'd0);
        @(negedge clk);
        check(!clr_en, "R8 one pulse", 32'(clr_en), 32'd0);
        check(mp_latch_en[50] == 1'b1, "R8 reopened", 32'(mp_latch_en[50]), 32'd1);
      end
    end
    check(seen, "R8 strobe seen", 32'(seen), 32'd1);
    drain();
  endtask

  task automatic t_ts_wrap();
    int base;
    strobe(259);
    base = nlog;
    inject(255, 6);
    drain();
    check(nlog - base == 1, "R9 count", 32'(nlog - base), 32'd1);
    check(wlog[base] == expw(ts_model, 255, 1, 2), "R9 wrapped stamp",
          32'(wlog[base]), 32'(expw(ts_model, 255, 1, 2)));
  endtask

  task automatic t_backpressure();
    int base;
    logic [19:0] first;
    base = nlog;
    out_ready = 1'b0;
    @(negedge clk);
    inj_req[12] = 16'h0401;  // (r0,c0) and (r2,c2)
    @(negedge clk);
    inj_req[12] = '0;
    repeat (4) @(negedge clk);
    first = out_data;
    check(out_valid, "R10 valid", 32'(out_valid), 32'd1);
    check(first == expw(ts_model, 12, 0, 0), "R10 word", 32'(first), 32'(expw(ts_model, 12, 0, 0)));
    repeat (3) @(negedge clk);
    check(out_valid && out_data == first, "R10 held", 32'(out_data), 32'(first));
    out_ready = 1'b1;
    drain();
    check(nlog - base == 2, "R10 count", 32'(nlog - base), 32'd2);
    check(wlog[base+1] == expw(ts_model, 12, 2, 2), "R10 second",
          32'(wlog[base+1]), 32'(expw(ts_model, 12, 2, 2)));
  endtask

  initial begin
    for (int m = 0; m < NMP; m++) inj_req[m] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_drop();
    t_order();
    t_empty_cols();
    t_prio();
    t_release();
    t_ts_wrap();
    t_backpressure();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule